// File: doc/BRIEF.md
# SPI Command Slave with Frame Validation

This block is the serial front end of a register-mapped peripheral. A master selects it with an active-low select line and clocks in a 16-bit frame. The first byte is an instruction and the second byte is data. While the instruction shifts in, the slave shifts out a status byte. That byte carries a fixed pattern and a flag telling the master whether the previous access was rejected. Instructions read one of the eight internal 8-bit registers, write one of them, or request a clear of diagnostics. A clear request is passed to the surrounding logic as a one-cycle strobe.

The slave is strict about what it accepts. It checks the chip address bits, the instruction code, odd parity, the busy input, the number of SCK falling edges, and the level of SCK when select returns high. A frame that fails any check changes no register and fires no strobe, and the flag is raised for the following frame. The SPI lines are oversampled in the system clock domain. SCK idles low. The master samples SO and the slave samples SI on rising SCK edges, and the slave moves SO to its next bit on falling edges.

Top module: `spi_cmd_slave`

## Requirements
- R1: During bits 0..7 of every frame SO carries the status byte {1010101, f}, MSB first. The flag f is 1 when the previous frame was rejected, and 0 after reset.
- R2: An instruction byte is {addr[1:0], code[4:0], p}. Codes 00000..00111 read register code[2:0]. During bits 8..15 of a read, SO carries that register MSB first, and the data bits on SI are ignored.
- R3: Codes 01000..01111 write the data byte to register code[2:0]. The write is applied after select rises, and it appears on cfg_q[8*i+7:8*i] for register i.
- R4: An instruction with addr not equal to 00, or with a code outside the read, write and clear ranges, is rejected. Bits 8..15 on SO are FFh, no register changes, and the flag is set.
- R5: A frame whose count of SCK falling edges while selected differs from 16 is rejected. It causes no write and no clear strobe, and sets the flag. SI bits beyond the 16th are discarded.
- R6: A write that ends with SCK high when select rises (a 17th bit) is suppressed and sets the flag.
- R7: Parity is odd over the 8 instruction bits. A parity error on a write suppresses the write. A parity error on a read still returns the register data. Either case sets the flag.
- R8: If busy is high at any point while selected, the frame is rejected. Bits 8..15 on SO are FFh, no register changes, and the flag is set.
- R9: During bits 8..15 of an accepted write or clear instruction, SO is 0.
- R10: Code 10000 in a valid 16-edge frame with correct parity produces exactly one diag_clr pulse of one clock. A rejected clear frame produces none.
- R11: spi_so_en is 0 during reset and while select is high, and 1 while a frame is in progress.
- R12: A frame that passes every check clears the flag for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI lines |
| rst | input | 1 | Active-high synchronous reset |
| spi_sck | input | 1 | Serial clock from the master, idle low |
| spi_ss_n | input | 1 | Slave select, active low |
| spi_si | input | 1 | Serial data from the master |
| spi_so | output | 1 | Serial data to the master |
| spi_so_en | output | 1 | Output enable for SO; the pad is high impedance when 0 |
| busy | input | 1 | High while the peripheral is still processing the previous access |
| diag_clr | output | 1 | One-cycle strobe for an accepted clear-diagnostics command |
| cfg_q | output | NREG*DW | Contents of the register file, register i in bits 8*i+7..8*i |

## Verification
Several properties are checked by assertions on every cycle. The register file never changes unless a write strobe is present, and the write and clear strobes are single-cycle and mutually exclusive. A frame that ends with the wrong falling-edge count yields neither strobe, the receive counter never passes 16, and the status byte begins with the pattern's leading bit. The remaining behaviours can only be shown by the bench's frame scenarios. These are the exact status byte and flag history across consecutive frames, the choice between register data, FFh and zero in the second byte, and the suppression of writes for a bad address, parity, busy, edge count or trailing SCK high, confirmed by reading the register back.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

   typedef enum logic [1:0] {
      CMD_NONE = 2'd0,
      CMD_RD   = 2'd1,
      CMD_WR   = 2'd2,
      CMD_CLR  = 2'd3
   } cmd_e;

   localparam logic [1:0] GRP_RD   = 2'b00;
   localparam logic [1:0] GRP_WR   = 2'b01;
   localparam logic [4:0] CODE_CLR = 5'b10000;

   // Instruction layout: [7:6] chip address, [5:1] code, [0] parity
   function automatic cmd_e decode_cmd(input logic [7:0] ins, input int nreg);
      logic [1:0] addr;
      logic [4:0] code;
      cmd_e       res;
      addr = ins[7:6];
      code = ins[5:1];
      res  = CMD_NONE;
      if (addr == 2'b00) begin
         if (code[4:3] == GRP_RD && int'(code[2:0]) < nreg)
            res = CMD_RD;
         else if (code[4:3] == GRP_WR && int'(code[2:0]) < nreg)
            res = CMD_WR;
         else if (code == CODE_CLR)
            res = CMD_CLR;
      end
      return res;
   endfunction

endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
   parameter int         STAGES  = 2,
   parameter int         W       = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) stg[i] <= RST_VAL;
            else     stg[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) stg[i] <= RST_VAL;
            else     stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_cmd_regfile.sv
module spi_cmd_regfile #(
   parameter int NREG = 8,
   parameter int DW   = 8,
   localparam int IW  = $clog2(NREG)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr_en,
   input  logic [IW-1:0]      wr_idx,
   input  logic [DW-1:0]      wr_data,
   input  logic [IW-1:0]      rd_idx,
   output logic [DW-1:0]      rd_data,
   output logic [NREG*DW-1:0] regs_flat
);

   logic [DW-1:0] mem [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst)
            mem[i] <= '0;
         else if (wr_en && int'(wr_idx) == i)
            mem[i] <= wr_data;
      end
      assign regs_flat[i*DW +: DW] = mem[i];
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NREG; k++)
         if (int'(rd_idx) == k) rd_data = mem[k];
   end

   // Storage only moves on a write strobe from the frame logic
   assert_hold_without_write_R3: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(regs_flat));

endmodule

// File: rtl/spi_cmd_frame.sv
module spi_cmd_frame
   import spi_cmd_pkg::*;
#(
   parameter int         NREG    = 8,
   parameter int         DW      = 8,
   parameter logic [6:0] PATTERN = 7'b1010101,
   localparam int IW         = $clog2(NREG),
   localparam int FRAME_BITS = 2 * DW,
   localparam int CW         = $clog2(2 * FRAME_BITS)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ss_s,
   input  logic          sck_s,
   input  logic          si_s,
   input  logic          busy,
   input  logic [DW-1:0] rd_data,
   output logic [IW-1:0] rd_idx,
   output logic          wr_en,
   output logic [IW-1:0] wr_idx,
   output logic [DW-1:0] wr_data,
   output logic          diag_clr,
   output logic          so_bit,
   output logic          active
);

   localparam logic [CW-1:0] FB_C   = CW'(FRAME_BITS);
   localparam logic [CW-1:0] HEAD_C = CW'(DW - 1);

   logic ss_q, sck_q;
   logic sel_start, sel_end, sck_rise, sck_fall;
   logic [CW-1:0] rise_cnt, fall_cnt;
   logic [FRAME_BITS-1:0] rx_sr;
   logic [DW-1:0] tx_sr, second_byte;
   logic busy_seen, prev_bad;
   cmd_e head_cmd, end_cmd;
   logic head_bad, frame_bad, par_ok, cnt_ok;

   always_ff @(posedge clk) begin
      if (rst) begin
         ss_q  <= 1'b1;
         sck_q <= 1'b0;
      end else begin
         ss_q  <= ss_s;
         sck_q <= sck_s;
      end
   end

   assign active    = ~ss_s;
   assign sel_start = ss_q & ~ss_s;
   assign sel_end   = ~ss_q & ss_s;
   assign sck_rise  = active & sck_s & ~sck_q;
   assign sck_fall  = active & ~sck_s & sck_q;

   // Instruction as seen when the eighth falling edge arrives
   assign head_cmd = decode_cmd(rx_sr[DW-1:0], NREG);
   assign head_bad = (head_cmd == CMD_NONE) | busy_seen | busy;
   assign rd_idx   = rx_sr[IW:1];

   always_comb begin
      if (head_bad)                second_byte = '1;
      else if (head_cmd == CMD_RD) second_byte = rd_data;
      else                         second_byte = '0;
   end

   // Whole-frame evaluation at select release
   assign end_cmd   = decode_cmd(rx_sr[FRAME_BITS-1:DW], NREG);
   assign par_ok    = ^rx_sr[FRAME_BITS-1:DW];
   assign cnt_ok    = (fall_cnt == FB_C);
   assign frame_bad = (end_cmd == CMD_NONE) | busy_seen | busy | ~cnt_ok | ~par_ok
                    | ((end_cmd == CMD_WR) & sck_s);

   always_ff @(posedge clk) begin
      if (rst) begin
         rise_cnt  <= '0;
         fall_cnt  <= '0;
         rx_sr     <= '0;
         tx_sr     <= '0;
         busy_seen <= 1'b0;
         prev_bad  <= 1'b0;
         wr_en     <= 1'b0;
         diag_clr  <= 1'b0;
         wr_idx    <= '0;
         wr_data   <= '0;
      end else begin
         wr_en    <= 1'b0;
         diag_clr <= 1'b0;
         if (sel_start) begin
            rise_cnt  <= '0;
            fall_cnt  <= '0;
            rx_sr     <= '0;
            busy_seen <= busy;
            tx_sr     <= {PATTERN, prev_bad};
         end else if (active) begin
            if (busy) busy_seen <= 1'b1;
            if (sck_rise && rise_cnt < FB_C) begin
               rx_sr    <= {rx_sr[FRAME_BITS-2:0], si_s};
               rise_cnt <= rise_cnt + 1'b1;
            end
            if (sck_fall) begin
               if (fall_cnt != '1) fall_cnt <= fall_cnt + 1'b1;
               if (fall_cnt == HEAD_C) tx_sr <= second_byte;
               else                    tx_sr <= {tx_sr[DW-2:0], 1'b0};
            end
         end
         if (sel_end) begin
            prev_bad <= frame_bad;
            wr_en    <= ~frame_bad & (end_cmd == CMD_WR);
            diag_clr <= ~frame_bad & (end_cmd == CMD_CLR);
            wr_idx   <= rx_sr[DW+IW:DW+1];
            wr_data  <= rx_sr[DW-1:0];
         end
      end
   end

   assign so_bit = tx_sr[DW-1];

   assert_status_lead_R1: assert property (@(posedge clk) disable iff (rst)
      sel_start |=> (so_bit == PATTERN[6]));

   assert_strobe_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> !diag_clr);

   assert_clear_single_R10: assert property (@(posedge clk) disable iff (rst)
      diag_clr |=> !diag_clr);

   assert_bad_count_blocks_R5: assert property (@(posedge clk) disable iff (rst)
      (sel_end && fall_cnt != FB_C) |=> (!wr_en && !diag_clr));

   assert_rx_cap_R5: assert property (@(posedge clk) disable iff (rst)
      rise_cnt <= FB_C);

endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave #(
   parameter int         NREG        = 8,
   parameter int         DW          = 8,
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] PATTERN     = 7'b1010101,
   localparam int IW = $clog2(NREG)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               spi_sck,
   input  logic               spi_ss_n,
   input  logic               spi_si,
   output logic               spi_so,
   output logic               spi_so_en,
   input  logic               busy,
   output logic               diag_clr,
   output logic [NREG*DW-1:0] cfg_q
);

   if (DW != 8) begin : g_chk_dw
      $error("spi_cmd_slave: DW must be 8");
   end
   if (NREG < 2 || NREG > 8) begin : g_chk_nreg
      $error("spi_cmd_slave: NREG must lie in 2..8");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("spi_cmd_slave: SYNC_STAGES must be at least 2");
   end

   logic [2:0]    pins_s;
   logic          ss_s, sck_s, si_s, so_bit, active, wr_en;
   logic [IW-1:0] rd_idx, wr_idx;
   logic [DW-1:0] rd_data, wr_data;

   spi_cmd_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   ({spi_ss_n, spi_sck, spi_si}),
      .q   (pins_s)
   );

   assign ss_s  = pins_s[2];
   assign sck_s = pins_s[1];
   assign si_s  = pins_s[0];

   spi_cmd_frame #(.NREG(NREG), .DW(DW), .PATTERN(PATTERN)) u_frame (
      .clk      (clk),
      .rst      (rst),
      .ss_s     (ss_s),
      .sck_s    (sck_s),
      .si_s     (si_s),
      .busy     (busy),
      .rd_data  (rd_data),
      .rd_idx   (rd_idx),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .diag_clr (diag_clr),
      .so_bit   (so_bit),
      .active   (active)
   );

   spi_cmd_regfile #(.NREG(NREG), .DW(DW)) u_regs (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .rd_idx    (rd_idx),
      .rd_data   (rd_data),
      .regs_flat (cfg_q)
   );

   assign spi_so_en = active & ~rst;
   assign spi_so    = spi_so_en & so_bit;

endmodule

// File: tb/tb_spi_cmd_slave.sv
`timescale 1ns/1ps
module tb_spi_cmd_slave;

   logic clk = 1'b0;
   logic rst, sck, ss_n, si, busy;
   logic so, so_en, diag_clr;
   logic [63:0] cfg_q;

   int checks = 0;
   int fails  = 0;
   int dcnt   = 0;

   logic [15:0] exp_q[$];
   logic [15:0] msk_q[$];
   string       tag_q[$];
   logic [15:0] got;
   event        frame_done;

   always #5 clk = ~clk;

   spi_cmd_slave dut (
      .clk(clk), .rst(rst), .spi_sck(sck), .spi_ss_n(ss_n), .spi_si(si),
      .spi_so(so), .spi_so_en(so_en), .busy(busy), .diag_clr(diag_clr),
      .cfg_q(cfg_q)
   );

   always @(posedge clk) if (!rst && diag_clr) dcnt <= dcnt + 1;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Monitor: pops the expected response and compares it with the captured one
   initial forever begin
      @(frame_done);
      begin
         logic [15:0] e, m;
         string t;
         e = exp_q.pop_front();
         m = msk_q.pop_front();
         t = tag_q.pop_front();
         check(t, {48'd0, got & m}, {48'd0, e & m});
      end
   end

   function automatic logic [7:0] mk(input logic [1:0] a, input logic [4:0] c, input bit badpar);
      logic p;
      p = ~^{a, c};
      return {a, c, p ^ badpar};
   endfunction

   // Driver: queues the expected response, then plays one frame
   task automatic frame(input logic [7:0] ins, input logic [7:0] dat, input int nfall,
                        input bit hi17, input logic [15:0] exp, input logic [15:0] msk,
                        input string tag);
      logic [15:0] bits;
      bits = {ins, dat};
      exp_q.push_back(exp);
      msk_q.push_back(msk);
      tag_q.push_back(tag);
      got = '0;
      @(negedge clk) ss_n = 1'b0;
      repeat (8) @(negedge clk);
      for (int i = 0; i < nfall; i++) begin
         si = (i < 16) ? bits[15-i] : 1'b0;
         repeat (8) @(negedge clk);
         if (i < 16) got[15-i] = so;
         sck = 1'b1;
         repeat (8) @(negedge clk);
         sck = 1'b0;
      end
      repeat (8) @(negedge clk);
      if (hi17) begin
         sck = 1'b1;
         repeat (8) @(negedge clk);
         ss_n = 1'b1;
         repeat (8) @(negedge clk);
         sck = 1'b0;
      end else begin
         ss_n = 1'b1;
      end
      repeat (16) @(negedge clk);
      -> frame_done;
      #1;
   endtask

   initial begin
      #2000000;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst = 1'b1; sck = 1'b0; ss_n = 1'b1; si = 1'b0; busy = 1'b0;
      repeat (4) @(negedge clk);
      check("R11 so_en in reset", {63'd0, so_en}, 64'd0);
      rst = 1'b0;
      repeat (4) @(negedge clk);
      check("R11 so_en idle", {63'd0, so_en}, 64'd0);
      check("R3 regs after reset", cfg_q, 64'd0);
      check("R10 no strobe after reset", {63'd0, diag_clr}, 64'd0);

      // R1 R2: plain read, flag clear after reset
      frame(mk(2'b00, 5'b00011, 0), 8'h00, 16, 0, 16'hAA00, 16'hFFFF, "R1 R2 read r3 after reset");
      // R9: write returns zero in second byte
      frame(mk(2'b00, 5'b01011, 0), 8'h5A, 16, 0, 16'hAA00, 16'hFFFF, "R9 write r3 response");
      check("R3 cfg_q r3 written", {56'd0, cfg_q[31:24]}, 64'h5A);
      // R2: read data, SI bits ignored
      frame(mk(2'b00, 5'b00011, 0), 8'hFF, 16, 0, 16'hAA5A, 16'hFFFF, "R2 read r3 with SI ones");
      frame(mk(2'b00, 5'b00011, 0), 8'h00, 16, 0, 16'hAA5A, 16'hFFFF, "R2 read r3 unchanged");
      check("R2 cfg_q unchanged by read", cfg_q, 64'h0000_0000_5A00_0000);
      // R4: unused code
      frame(mk(2'b00, 5'b10001, 0), 8'h00, 16, 0, 16'hAAFF, 16'hFFFF, "R4 unused code FF");
      frame(mk(2'b00, 5'b00011, 0), 8'h00, 16, 0, 16'hAB5A, 16'hFFFF, "R4 flag after unused code");
      // R4: wrong chip address
      frame(mk(2'b01, 5'b01011, 0), 8'h11, 16, 0, 16'hAAFF, 16'hFFFF, "R4 bad address FF");
      check("R4 bad address no write", {56'd0, cfg_q[31:24]}, 64'h5A);
      // R5: short and long frames
      frame(mk(2'b00, 5'b01101, 0), 8'hC3, 15, 0, 16'hAB00, 16'hFF00, "R5 short write status");
      frame(mk(2'b00, 5'b00101, 0), 8'h00, 16, 0, 16'hAB00, 16'hFFFF, "R5 short write suppressed");
      frame(mk(2'b00, 5'b01101, 0), 8'hC3, 17, 0, 16'hAA00, 16'hFFFF, "R5 long write response");
      check("R5 long write no commit", {56'd0, cfg_q[47:40]}, 64'h00);
      // R6: SCK high at select release
      frame(mk(2'b00, 5'b01101, 0), 8'hC3, 16, 1, 16'hAB00, 16'hFFFF, "R6 trailing high write");
      frame(mk(2'b00, 5'b00101, 0), 8'h00, 16, 0, 16'hAB00, 16'hFFFF, "R6 write suppressed");
      // R7: parity
      frame(mk(2'b00, 5'b01101, 1), 8'hC3, 16, 0, 16'hAA00, 16'hFFFF, "R7 bad parity write");
      frame(mk(2'b00, 5'b00011, 1), 8'h00, 16, 0, 16'hAB5A, 16'hFFFF, "R7 bad parity read data");
      frame(mk(2'b00, 5'b00101, 0), 8'h00, 16, 0, 16'hAB00, 16'hFFFF, "R7 flag and no write");
      // R8: busy
      busy = 1'b1;
      frame(mk(2'b00, 5'b01101, 0), 8'hC3, 16, 0, 16'hAAFF, 16'hFFFF, "R8 busy FF");
      busy = 1'b0;
      frame(mk(2'b00, 5'b00101, 0), 8'h00, 16, 0, 16'hAB00, 16'hFFFF, "R8 busy suppressed write");
      // R10: clear strobe
      frame(mk(2'b00, 5'b10000, 0), 8'h00, 16, 0, 16'hAA00, 16'hFFFF, "R9 clear response");
      check("R10 one clear strobe", dcnt, 64'd1);
      frame(mk(2'b00, 5'b10000, 0), 8'h00, 15, 0, 16'hAA00, 16'hFF00, "R10 short clear status");
      check("R10 no strobe on short clear", dcnt, 64'd1);
      // R12: good write after a bad frame clears flag
      frame(mk(2'b00, 5'b01101, 0), 8'hC3, 16, 0, 16'hAB00, 16'hFFFF, "R12 write after bad");
      frame(mk(2'b00, 5'b00101, 0), 8'h00, 16, 0, 16'hAAC3, 16'hFFFF, "R12 R3 flag clear and data");

      // R11: enable during a frame
      @(negedge clk) ss_n = 1'b0;
      repeat (8) @(negedge clk);
      check("R11 so_en during frame", {63'd0, so_en}, 64'd1);
      ss_n = 1'b1;
      repeat (8) @(negedge clk);
      check("R11 so_en after frame", {63'd0, so_en}, 64'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule